// File: doc/BRIEF.md
# Addressed-Frame Serial Receiver

This block receives asynchronous serial frames on one line shared by several controllers. Each frame carries an eight-bit payload and one extra flag bit. The flag bit marks the frame as an address (ID) frame or a payload frame. Software arms an ID hunt by setting a control bit. While the hunt is armed, the hardware throws away every payload frame. The first ID frame that arrives is then handed to software, which compares it with its own address and decides whether to keep the payload frames that follow.

The receiver oversamples the line at sixteen ticks per bit. It confirms a start bit at the bit's midpoint and decides each later bit by a vote of three samples. It checks the stop bit, keeps the received byte in a data register and raises a level interrupt request. An overrun or framing error stays flagged, and while either flag is set no new frame is accepted. A status bit shows the live line level, so software can tell a break from a single corrupted frame.

A small register interface with a 2-bit address holds three registers: control at 0, status at 1 and receive data at 2. Reads are combinational. Writes take one clock.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is one low start bit, eight payload bits sent least significant bit first, one flag bit and one high stop bit. A frame that is accepted puts its payload in the data register at address 2 and sets status bit 0 (full).
- R2: The start bit is confirmed by one sample at its midpoint. A low pulse shorter than half a bit starts no frame. Each later bit takes the majority of three samples around its centre, so a glitch one tick long does not change the byte.
- R3: While control bit 1 (hunt) is 1, a frame with a good stop bit and flag bit 0 is dropped. It leaves the data register, full, overrun and the interrupt unchanged.
- R4: While hunt is 1, a frame with flag bit 1 is loaded like any other frame and clears hunt to 0 by itself. Writing 1 to hunt starts a new ID hunt.
- R5: rx_irq is high whenever full is 1 and control bit 2 (interrupt enable) is 1. It rises in the same cycle that full rises.
- R6: Writing the status register clears each of full (bit 0), overrun (bit 1) and framing (bit 2) whose write-data bit is 0. A write-data bit of 1 leaves that flag unchanged.
- R7: If a frame with a good stop bit would be loaded while full is 1, status bit 1 (overrun) is set and the data register keeps its old byte.
- R8: A stop bit whose vote is 0 sets status bit 2 (framing error). The data register and full stay unchanged.
- R9: While overrun or framing error is 1, no frame starts or completes. Reception resumes once software has cleared both flags.
- R10: Status bit 3 shows the synchronised level of the serial input at all times, including during a break.
- R11: While control bit 0 (receive enable) is 0, the receiver is held idle and nothing is received. Clearing the bit in the middle of a frame abandons that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 3 | Write data; only three bits are writable in any register |
| bus_rdata | output | 8 | Combinational read data of the register at bus_addr |
| rx_irq | output | 1 | Receive interrupt request (level) |

## Verification
The hardest case to reach from the ports is the order of events in the hunt filter. A payload frame has to be dropped while a byte that software left unread is still in place. Then an ID frame has to arrive, and only after that can an overrun occur. A vector table walks one continuous frame sequence and clears the flags only on the rows that need it. The data register therefore carries old bytes across drops, an overrun and a framing error. Directed tests then inject a glitch one tick wide at a bit centre, a short false start, a long break held for many bit times, and frames that arrive while an error flag is pending.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // sixteen oversample ticks per bit; centre tick of a bit
  localparam int unsigned OVS_LOG2 = 4;
  localparam logic [OVS_LOG2-1:0] TICK_MID  = 4'd8;
  localparam logic [OVS_LOG2-1:0] TICK_LAST = 4'd15;

  // register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // a status flag survives a write unless its write-data bit is 0
  function automatic logic flag_kept(input logic wr, input logic wbit);
    return !(wr && !wbit);
  endfunction

endpackage

// File: rtl/mprx_tick_gen.sv
module mprx_tick_gen #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_TOP) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == CNT_TOP);

  assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/mprx_frame_engine.sv
module mprx_frame_engine
  import mprx_pkg::*;
#(
  parameter int unsigned NDATA = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic             rx_on,
  input  logic             accept,
  output logic             frame_done,
  output logic [NDATA-1:0] frame_byte,
  output logic             frame_flag,
  output logic             stop_ok,
  output logic             line_lvl
);
  localparam int unsigned FRAME_BITS = NDATA + 1;
  localparam int unsigned IDXW = $clog2(FRAME_BITS);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_BITS - 1);

  rx_state_e st_q;
  logic [OVS_LOG2-1:0] cnt_q;
  logic [IDXW-1:0] idx_q;
  logic [FRAME_BITS-1:0] sreg_q;
  logic rx_m, rx_s, armed_q;
  logic smp_a, smp_b;
  logic done_q, stop_q;
  logic vote;
  logic at_a, at_b, at_c;

  assign vote = vote3(smp_a, smp_b, rx_s);
  assign at_a = (cnt_q == TICK_MID - 1'b1);
  assign at_b = (cnt_q == TICK_MID);
  assign at_c = (cnt_q == TICK_MID + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m    <= 1'b1;
      rx_s    <= 1'b1;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sreg_q  <= '0;
      armed_q <= 1'b0;
      smp_a   <= 1'b1;
      smp_b   <= 1'b1;
      done_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      rx_m   <= rxd;
      rx_s   <= rx_m;
      done_q <= 1'b0;
      if (!rx_on) begin
        st_q    <= RX_IDLE;
        cnt_q   <= '0;
        armed_q <= rx_s;
      end else if (tick) begin
        unique case (st_q)
          RX_IDLE: begin
            armed_q <= rx_s;
            if (accept && armed_q && !rx_s) begin
              st_q  <= RX_START;
              cnt_q <= 4'd1;
            end
          end
          RX_START: begin
            cnt_q <= cnt_q + 1'b1;
            if (at_b && rx_s) begin
              st_q <= RX_IDLE;
            end else if (cnt_q == TICK_LAST) begin
              st_q  <= RX_BITS;
              idx_q <= '0;
            end
          end
          RX_BITS: begin
            cnt_q <= cnt_q + 1'b1;
            if (at_a) smp_a <= rx_s;
            if (at_b) smp_b <= rx_s;
            if (at_c) sreg_q <= {vote, sreg_q[FRAME_BITS-1:1]};
            if (cnt_q == TICK_LAST) begin
              if (idx_q == LAST_IDX) st_q <= RX_STOP;
              else idx_q <= idx_q + 1'b1;
            end
          end
          RX_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (at_a) smp_a <= rx_s;
            if (at_b) smp_b <= rx_s;
            if (at_c) begin
              done_q  <= 1'b1;
              stop_q  <= vote;
              st_q    <= RX_IDLE;
              armed_q <= 1'b0;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign frame_done = done_q;
  assign frame_byte = sreg_q[NDATA-1:0];
  assign frame_flag = sreg_q[NDATA];
  assign stop_ok    = stop_q;
  assign line_lvl   = rx_s;

  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> (st_q == RX_IDLE));

  assert_no_start_when_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE) && !accept |=> (st_q == RX_IDLE));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

// File: rtl/mprx_regs.sv
module mprx_regs
  import mprx_pkg::*;
#(
  parameter int unsigned NDATA = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             stat_wr,
  input  logic [2:0]       wbits,
  input  logic             frame_done,
  input  logic [NDATA-1:0] frame_byte,
  input  logic             frame_flag,
  input  logic             stop_ok,
  output logic             rx_on,
  output logic             hunt,
  output logic             irq_en,
  output logic             full,
  output logic             ovr,
  output logic             frm,
  output logic             last_flag,
  output logic [NDATA-1:0] data,
  output logic             accept,
  output logic             rx_irq
);
  logic rx_on_q, hunt_q, irq_en_q, full_q, ovr_q, frm_q, flag_q;
  logic [NDATA-1:0] data_q;
  logic full_eff;
  // named events for the checks below
  logic drop_ev, load_ev, overrun_ev, bad_ev;

  assign full_eff   = full_q & flag_kept(stat_wr, wbits[0]);
  assign bad_ev     = frame_done & ~stop_ok;
  assign drop_ev    = frame_done & stop_ok & hunt_q & ~frame_flag;
  assign load_ev    = frame_done & stop_ok & ~drop_ev & ~full_eff;
  assign overrun_ev = frame_done & stop_ok & ~drop_ev & full_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on_q  <= 1'b0;
      hunt_q   <= 1'b0;
      irq_en_q <= 1'b0;
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
      frm_q    <= 1'b0;
      flag_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      full_q <= full_eff | load_ev;
      ovr_q  <= (ovr_q & flag_kept(stat_wr, wbits[1])) | overrun_ev;
      frm_q  <= (frm_q & flag_kept(stat_wr, wbits[2])) | bad_ev;
      if (load_ev) begin
        data_q <= frame_byte;
        flag_q <= frame_flag;
      end
      if (ctrl_wr) begin
        rx_on_q  <= wbits[0];
        hunt_q   <= wbits[1];
        irq_en_q <= wbits[2];
      end else if (load_ev && frame_flag) begin
        hunt_q <= 1'b0;
      end
    end
  end

  assign rx_on     = rx_on_q;
  assign hunt      = hunt_q;
  assign irq_en    = irq_en_q;
  assign full      = full_q;
  assign ovr       = ovr_q;
  assign frm       = frm_q;
  assign last_flag = flag_q;
  assign data      = data_q;
  assign accept    = rx_on_q & ~ovr_q & ~frm_q;
  assign rx_irq    = full_q & irq_en_q;

  assert_drop_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> (data_q == $past(data_q)) && !$rose(full_q) && !$rose(ovr_q));

  assert_id_ends_hunt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev && frame_flag && hunt_q && !ctrl_wr |=> !hunt_q && full_q);

  assert_irq_with_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) && irq_en_q |-> rx_irq);

  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> ovr_q && (data_q == $past(data_q)));

  assert_bad_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ev |=> frm_q && (data_q == $past(data_q)));

  assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q || frm_q) |-> !frame_done);

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mprx_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned NDATA    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [2:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rx_irq
);
  logic tick;
  logic frame_done, frame_flag, stop_ok, line_lvl;
  logic [NDATA-1:0] frame_byte, data;
  logic rx_on, hunt, irq_en, full, ovr, frm, last_flag, accept;
  logic ctrl_wr, stat_wr;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign stat_wr = bus_wr && (bus_addr == ADDR_STAT);

  mprx_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  mprx_frame_engine #(.NDATA(NDATA)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rxd       (rxd),
    .rx_on     (rx_on),
    .accept    (accept),
    .frame_done(frame_done),
    .frame_byte(frame_byte),
    .frame_flag(frame_flag),
    .stop_ok   (stop_ok),
    .line_lvl  (line_lvl)
  );

  mprx_regs #(.NDATA(NDATA)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .stat_wr   (stat_wr),
    .wbits     (bus_wdata),
    .frame_done(frame_done),
    .frame_byte(frame_byte),
    .frame_flag(frame_flag),
    .stop_ok   (stop_ok),
    .rx_on     (rx_on),
    .hunt      (hunt),
    .irq_en    (irq_en),
    .full      (full),
    .ovr       (ovr),
    .frm       (frm),
    .last_flag (last_flag),
    .data      (data),
    .accept    (accept),
    .rx_irq    (rx_irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {5'b0, irq_en, hunt, rx_on};
      ADDR_STAT: bus_rdata = {3'b0, last_flag, line_lvl, frm, ovr, full};
      ADDR_DATA: bus_rdata = 8'(data);
      default:   bus_rdata = '0;
    endcase
  end

  assert_line_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_lvl) |-> $past(rxd, 2) == 1'b0);

  assert_irq_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> full);

endmodule

// File: tb/sim_mp_uart_rx.sv
`timescale 1ns/1ps
module sim_mp_uart_rx;
  localparam int BIT_CLKS = 64;  // TICK_DIV 4 x 16 ticks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [2:0] bus_wdata = 3'd0;
  logic [7:0] bus_rdata;
  logic rx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mp_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_irq(rx_irq)
  );

  typedef struct packed {
    logic       hunt;
    logic [7:0] dat;
    logic       flag;
    logic       good;
    logic       clr;
    logic       e_full;
    logic [7:0] e_data;
    logic       e_ovr;
    logic       e_frm;
    logic       e_hunt;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{1'b0, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h33, 1'b0, 1'b1, 1'b1, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'hC4, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC4, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h77, 1'b0, 1'b1, 1'b1, 1'b1, 8'hC4, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h88, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC4, 1'b0, 1'b1, 1'b0},
    '{1'b1, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC4, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic flag,
                            input logic good, input int glitch_bit);
    logic [10:0] bits;
    bits = {good, flag, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      for (int c = 0; c < BIT_CLKS; c++) begin
        rxd = (i == glitch_bit && c >= 32 && c < 36) ? ~bits[i] : bits[i];
        @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, keep;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd_reg(2'd0, v); check("R11 reset ctrl", v, 8'h00);
    rd_reg(2'd1, v); check("R10 reset status line high", v, 8'h08);
    rd_reg(2'd2, v); check("R1 reset data", v, 8'h00);
    check("R5 reset irq", rx_irq, 0);

    wr_reg(2'd0, 3'b111);
    repeat (20) @(negedge clk);

    for (int r = 0; r < 9; r++) begin
      if (VEC[r].hunt) wr_reg(2'd0, 3'b111);
      send_frame(VEC[r].dat, VEC[r].flag, VEC[r].good, -1);
      rd_reg(2'd1, v);
      check($sformatf("R1 R3 full row %0d", r), v[0], VEC[r].e_full);
      check($sformatf("R7 overrun row %0d", r), v[1], VEC[r].e_ovr);
      check($sformatf("R8 framing row %0d", r), v[2], VEC[r].e_frm);
      rd_reg(2'd2, v);
      check($sformatf("R1 R3 R7 data row %0d", r), v, VEC[r].e_data);
      rd_reg(2'd0, v);
      check($sformatf("R4 hunt row %0d", r), v[1], VEC[r].e_hunt);
      check($sformatf("R5 irq row %0d", r), rx_irq, VEC[r].e_full);
      if (VEC[r].clr) wr_reg(2'd1, 3'b000);
    end

    // R9: a pending framing error blocks the next frame
    rd_reg(2'd2, keep);
    send_frame(8'h10, 1'b0, 1'b0, -1);
    send_frame(8'h3C, 1'b0, 1'b1, -1);
    rd_reg(2'd1, v); check("R9 held full", v[0], 0);
    check("R9 framing still set", v[2], 1);
    rd_reg(2'd2, v); check("R9 data unchanged", v, keep);
    wr_reg(2'd1, 3'b000);
    send_frame(8'h3C, 1'b0, 1'b1, -1);
    rd_reg(2'd2, v); check("R9 resumes", v, 8'h3C);
    wr_reg(2'd1, 3'b000);

    // R5: interrupt masked then enabled
    wr_reg(2'd0, 3'b001);
    send_frame(8'h66, 1'b0, 1'b1, -1);
    rd_reg(2'd1, v); check("R5 full with irq off", v[0], 1);
    check("R5 irq masked", rx_irq, 0);
    wr_reg(2'd0, 3'b101);
    @(negedge clk); check("R5 irq level on enable", rx_irq, 1);

    // R6: writing ones changes no flag, zero clears full only
    wr_reg(2'd1, 3'b111);
    rd_reg(2'd1, v); check("R6 write ones keeps full", v[2:0], 3'b001);
    wr_reg(2'd1, 3'b110);
    rd_reg(2'd1, v); check("R6 clear full", v[2:0], 3'b000);

    // R2: one-tick glitch at a bit centre
    send_frame(8'h0F, 1'b0, 1'b1, 5);
    rd_reg(2'd2, v); check("R2 glitch rejected", v, 8'h0F);
    wr_reg(2'd1, 3'b000);

    // R2: false start
    rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    rd_reg(2'd1, v); check("R2 false start ignored", v[2:0], 3'b000);

    // R11: receive disabled
    wr_reg(2'd0, 3'b100);
    send_frame(8'h55, 1'b0, 1'b1, -1);
    rd_reg(2'd1, v); check("R11 disabled no frame", v[2:0], 3'b000);

    // R11: disable in the middle of a frame
    wr_reg(2'd0, 3'b101);
    repeat (20) @(negedge clk);
    fork
      send_frame(8'hE7, 1'b0, 1'b1, -1);
      begin repeat (4 * BIT_CLKS) @(negedge clk); wr_reg(2'd0, 3'b100); end
    join
    wr_reg(2'd0, 3'b101);
    rd_reg(2'd1, v); check("R11 abandoned frame", v[2:0], 3'b000);

    // R10: break
    repeat (20) @(negedge clk);
    rxd = 1'b0;
    repeat (25 * BIT_CLKS) @(negedge clk);
    rd_reg(2'd1, v); check("R10 line low in break", v[3], 0);
    check("R8 break framing", v[2], 1);
    rxd = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    rd_reg(2'd1, v); check("R10 line high after break", v[3], 1);
    check("R9 framing held after break", v[2], 1);
    wr_reg(2'd1, 3'b000);
    send_frame(8'h81, 1'b1, 1'b1, -1);
    rd_reg(2'd2, v); check("R1 receive after break", v, 8'h81);
    rd_reg(2'd1, v); check("R1 flag bit reported", v[4], 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule